// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between an 8-bit host bus and three 16-bit down-counter channels of an interval timer. It decodes the two address bits into three count ports and one control port, interprets control bytes that configure a chosen channel, and turns single-byte bus writes into complete 16-bit count loads for that channel. The counting itself happens in separate channel blocks. This interface only passes configuration and load values to them and takes their live count back for reads.

Since the bus is narrower than a count, each channel keeps its own access setting from its most recent control byte. That setting decides whether a count transfer is the low byte alone, the high byte alone, or low then high. Independent write and read byte pointers track where each channel is within a two-byte transfer. A control byte can also freeze a channel's live count in a holding register, so that software can read a consistent value across two byte reads while the counter keeps running.

All bus strobes are sampled on the rising clock edge. Configuration and load strobes to the channels are registered and last for one cycle. Read data is combinational from the selected channel while chip select and read are both high.

Top module: `tmr_bus_if`

## Requirements
- R1: After reset, every channel has mode 0, BCD flag 0 and access setting low-then-high (2'b11). Both byte pointers point at the low byte, no count is held, and cfg_stb and load_stb are 0.
- R2: Addresses 0, 1 and 2 reach channels 0, 1 and 2, and address 3 reaches the control port. Any access made while cs is low has no effect on outputs or state.
- R3: A control byte written to address 3 selects the channel with bits 7:6 and the access setting with bits 5:4. Bits 3:1 become that channel's mode_o and bit 0 its bcd_o. With access 01, 10 or 11 it pulses that channel's cfg_stb for exactly one cycle after the write edge. It also resets both byte pointers to the low byte.
- R4: With access 01, each data write produces load_val = {8'h00, byte} and a one-cycle load_stb.
- R5: With access 10, each data write produces load_val = {byte, 8'h00} and a one-cycle load_stb.
- R6: With access 11, the first data write is held and produces no load. The second write produces load_val = {second byte, first byte} and a one-cycle load_stb. The sequence then restarts from the low byte.
- R7: A read returns the low byte (access 01), the high byte (access 10), or alternately low then high starting with the low byte (access 11). The read pointer advances only on reads.
- R8: A control byte with access 00 captures the selected channel's live count without changing its mode or access setting. Reads return the captured value until one full read sequence (one byte, or two for access 11) is done, and then follow the live count again. A second capture request while a value is held is ignored.
- R9: A configuring control byte (access other than 00) drops any held count on that channel.
- R10: A read at address 3 returns 8'h00. A control byte with bits 7:6 = 11 has no effect.
- R11: When rd and wr are both high, the write is carried out and the read has no effect on the read pointer or held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Port select: 0..2 channel, 3 control |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte |
| cur_cnt | input | 48 | Live counts of the channels, channel n in bits 16n+15:16n |
| cfg_stb | output | 3 | One-cycle pulse per channel on a configuring control byte |
| mode_o | output | 9 | Mode per channel, channel n in bits 3n+2:3n |
| bcd_o | output | 3 | Stored BCD flag per channel |
| load_stb | output | 3 | One-cycle pulse per channel when a full count is ready |
| load_val | output | 48 | Count value per channel, valid with load_stb |

## Verification
The bench goes after the split two-byte load. A design that loads on the low byte gives the channel a count with a stale high half, and one that does not restart after the high byte swaps halves on the next pair. Held counts are read while the live count changes underneath. A design that releases the hold too early, or that takes a second capture request, returns a torn or later value. Stimulus also places control bytes between the two halves of a transfer, uses channel select 3, and raises rd and wr together. Pointer reset, ignored commands and write priority each show up directly in later read bytes or load values.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 3;
    localparam int NCH    = 3;

    localparam logic [1:0] ACC_HOLD = 2'b00;
    localparam logic [1:0] ACC_LO   = 2'b01;
    localparam logic [1:0] ACC_HI   = 2'b10;
    localparam logic [1:0] ACC_BOTH = 2'b11;

    typedef struct packed {
        logic [1:0]        sel;
        logic [1:0]        acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_fields_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [1:0]        acc;
        logic              bcd;
        logic              wptr;
        logic              rptr;
        logic [BYTE_W-1:0] lo_hold;
        logic              held;
        logic [CNT_W-1:0]  held_val;
        logic              cfg_stb;
        logic              load_stb;
        logic [CNT_W-1:0]  load_val;
    } chan_st_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_bus_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output ctl_fields_t       fields_o
);
    always_comb begin
        fields_o.sel  = byte_i[7:6];
        fields_o.acc  = byte_i[5:4];
        fields_o.mode = byte_i[3:1];
        fields_o.bcd  = byte_i[0];
    end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hit,
    input  logic              cap_hit,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  ctl_fields_t       ctl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic              cfg_stb,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val
);
    chan_st_t st_d, st_q;
    logic [CNT_W-1:0] rd_src;

    always_comb begin
        rd_src = st_q.held ? st_q.held_val : live_cnt;
        case (st_q.acc)
            ACC_LO:   rd_byte = rd_src[BYTE_W-1:0];
            ACC_HI:   rd_byte = rd_src[CNT_W-1:BYTE_W];
            ACC_BOTH: rd_byte = st_q.rptr ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
            default:  rd_byte = '0;
        endcase
    end

    always_comb begin
        st_d          = st_q;
        st_d.cfg_stb  = 1'b0;
        st_d.load_stb = 1'b0;
        if (cfg_hit) begin
            st_d.mode    = ctl.mode;
            st_d.acc     = ctl.acc;
            st_d.bcd     = ctl.bcd;
            st_d.wptr    = 1'b0;
            st_d.rptr    = 1'b0;
            st_d.held    = 1'b0;
            st_d.cfg_stb = 1'b1;
        end else if (cap_hit && !st_q.held) begin
            st_d.held     = 1'b1;
            st_d.held_val = live_cnt;
        end
        if (wr_hit) begin
            case (st_q.acc)
                ACC_LO: begin
                    st_d.load_val = {{BYTE_W{1'b0}}, wdata};
                    st_d.load_stb = 1'b1;
                end
                ACC_HI: begin
                    st_d.load_val = {wdata, {BYTE_W{1'b0}}};
                    st_d.load_stb = 1'b1;
                end
                ACC_BOTH: begin
                    if (!st_q.wptr) begin
                        st_d.lo_hold = wdata;
                        st_d.wptr    = 1'b1;
                    end else begin
                        st_d.load_val = {wdata, st_q.lo_hold};
                        st_d.load_stb = 1'b1;
                        st_d.wptr     = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (rd_hit) begin
            if (st_q.acc == ACC_BOTH) st_d.rptr = !st_q.rptr;
            if (st_q.acc != ACC_BOTH || st_q.rptr) st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.acc  <= ACC_BOTH;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.mode;
    assign bcd      = st_q.bcd;
    assign cfg_stb  = st_q.cfg_stb;
    assign load_stb = st_q.load_stb;
    assign load_val = st_q.load_val;

    // R4
    load_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load_stb |-> $past(wr_hit));
    // R3
    cfg_after_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg_stb |-> $past(cfg_hit));
    // R6
    pair_high_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && st_q.acc == ACC_BOTH && !st_q.wptr) |=> !st_q.load_stb);
    // R8
    held_value_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !cfg_hit) |=> $stable(st_q.held_val));
    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !cfg_hit) |=> $stable(st_q.rptr));
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
    import tmr_bus_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs,
    input  logic                    rd,
    input  logic                    wr,
    input  logic [1:0]              addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NCH*CNT_W-1:0]    cur_cnt,
    output logic [NCH-1:0]          cfg_stb,
    output logic [NCH*MODE_W-1:0]   mode_o,
    output logic [NCH-1:0]          bcd_o,
    output logic [NCH-1:0]          load_stb,
    output logic [NCH*CNT_W-1:0]    load_val
);
    localparam logic [1:0] CTL_ADDR = 2'(NCH);

    ctl_fields_t       ctl;
    logic              ctl_wr;
    logic [BYTE_W-1:0] rd_bytes [NCH];
    logic [NCH-1:0]    cfg_hit, cap_hit, wr_hit, rd_hit;

    tmr_ctl_decode u_dec (.byte_i(wdata), .fields_o(ctl));

    assign ctl_wr = cs && wr && (addr == CTL_ADDR);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            assign cfg_hit[g] = ctl_wr && (ctl.sel == 2'(g)) && (ctl.acc != ACC_HOLD);
            assign cap_hit[g] = ctl_wr && (ctl.sel == 2'(g)) && (ctl.acc == ACC_HOLD);
            assign wr_hit[g]  = cs && wr && (addr == 2'(g));
            assign rd_hit[g]  = cs && rd && !wr && (addr == 2'(g));

            tmr_chan_regs u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_hit  (cfg_hit[g]),
                .cap_hit  (cap_hit[g]),
                .wr_hit   (wr_hit[g]),
                .rd_hit   (rd_hit[g]),
                .ctl      (ctl),
                .wdata    (wdata),
                .live_cnt (cur_cnt[g*CNT_W +: CNT_W]),
                .rd_byte  (rd_bytes[g]),
                .mode     (mode_o[g*MODE_W +: MODE_W]),
                .bcd      (bcd_o[g]),
                .cfg_stb  (cfg_stb[g]),
                .load_stb (load_stb[g]),
                .load_val (load_val[g*CNT_W +: CNT_W])
            );
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (cs && rd && addr != CTL_ADDR) rdata = rd_bytes[addr];
    end

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_hit, ctl_wr}));
    // R10
    no_sel3_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl.sel == 2'b11) |=> (cfg_stb == '0));
endmodule

// File: tb/tb_tmr_bus_if.sv
module tb_tmr_bus_if;
    localparam int PERIOD = 10;

    logic        clk = 0, rst_n = 0, cs = 0, rd = 0, wr = 0;
    logic [1:0]  addr = 0;
    logic [7:0]  wdata = 0, rdata;
    logic [15:0] cur [3];
    logic [47:0] cur_cnt, load_val;
    logic [2:0]  cfg_stb, bcd_o, load_stb;
    logic [8:0]  mode_o;

    assign cur_cnt = {cur[2], cur[1], cur[0]};
    always #(PERIOD/2) clk = ~clk;

    tmr_bus_if dut (.clk, .rst_n, .cs, .rd, .wr, .addr, .wdata, .rdata, .cur_cnt,
                    .cfg_stb, .mode_o, .bcd_o, .load_stb, .load_val);

    int checks = 0, errors = 0;
    logic [2:0]  m_mode [3];
    logic [1:0]  m_acc [3];
    logic        m_bcd [3], m_wp [3], m_rp [3], m_held [3], e_cfg [3], e_ld [3];
    logic [7:0]  m_lo [3];
    logic [15:0] m_hv [3], e_lv [3];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(int c);
        logic [15:0] s = m_held[c] ? m_hv[c] : cur[c];
        case (m_acc[c])
            2'b01: return s[7:0];
            2'b10: return s[15:8];
            2'b11: return m_rp[c] ? s[15:8] : s[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_mode[c] = 0; m_acc[c] = 2'b11; m_bcd[c] = 0; m_wp[c] = 0; m_rp[c] = 0;
            m_held[c] = 0; m_lo[c] = 0; m_hv[c] = 0; e_cfg[c] = 0; e_ld[c] = 0; e_lv[c] = 0;
        end
    endtask

    task automatic model_step(logic c_s, logic r, logic w, logic [1:0] a, logic [7:0] d);
        for (int c = 0; c < 3; c++) begin e_cfg[c] = 0; e_ld[c] = 0; end
        if (!c_s) return;
        if (w && a == 3) begin
            if (d[7:6] != 3) begin
                int c = d[7:6];
                if (d[5:4] == 0) begin
                    if (!m_held[c]) begin m_held[c] = 1; m_hv[c] = cur[c]; end
                end else begin
                    m_mode[c] = d[3:1]; m_acc[c] = d[5:4]; m_bcd[c] = d[0];
                    m_wp[c] = 0; m_rp[c] = 0; m_held[c] = 0; e_cfg[c] = 1;
                end
            end
        end else if (w) begin
            int c = a;
            if (m_acc[c] == 1) begin e_ld[c] = 1; e_lv[c] = {8'h00, d}; end
            else if (m_acc[c] == 2) begin e_ld[c] = 1; e_lv[c] = {d, 8'h00}; end
            else if (!m_wp[c]) begin m_lo[c] = d; m_wp[c] = 1; end
            else begin e_ld[c] = 1; e_lv[c] = {d, m_lo[c]}; m_wp[c] = 0; end
        end else if (r && a != 3) begin
            int c = a;
            if (m_acc[c] != 3 || m_rp[c]) m_held[c] = 0;
            if (m_acc[c] == 3) m_rp[c] = !m_rp[c];
        end
    endtask

    task automatic op(logic c_s, logic r, logic w, logic [1:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        cs = c_s; rd = r; wr = w; addr = a; wdata = d;
        #1;
        if (c_s && r) chk({tag, " rdata"}, {8'h00, rdata},
                          {8'h00, (a == 3) ? 8'h00 : exp_rd(a)});
        else chk({tag, " rdata idle"}, {8'h00, rdata}, 16'h0000);
        @(posedge clk);
        model_step(c_s, r, w, a, d);
        #1;
        cs = 0; rd = 0; wr = 0;
        for (int c = 0; c < 3; c++) begin
            chk({tag, " cfg_stb"}, {15'h0, cfg_stb[c]}, {15'h0, e_cfg[c]});
            chk({tag, " load_stb"}, {15'h0, load_stb[c]}, {15'h0, e_ld[c]});
            if (e_ld[c]) chk({tag, " load_val"}, load_val[c*16 +: 16], e_lv[c]);
            chk({tag, " mode"}, {13'h0, mode_o[c*3 +: 3]}, {13'h0, m_mode[c]});
            chk({tag, " bcd"}, {15'h0, bcd_o[c]}, {15'h0, m_bcd[c]});
        end
    endtask

    task automatic rd_check(logic [1:0] a, string tag);
        op(1, 1, 0, a, 8'h00, tag);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        cur[0] = 16'h1234; cur[1] = 16'hABCD; cur[2] = 16'h0F0F;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        // R1 reset state
        chk("R1 cfg_stb", {13'h0, cfg_stb}, 16'h0);
        chk("R1 load_stb", {13'h0, load_stb}, 16'h0);
        chk("R1 mode", {7'h0, mode_o}, 16'h0);
        rd_check(0, "R1 low first");
        rd_check(0, "R1 then high");

        // R4 low byte only, channel 0 mode 2
        op(1, 0, 1, 3, 8'b00_01_010_1, "R3 ctl ch0");
        op(1, 0, 1, 0, 8'h34, "R4 low load");
        rd_check(0, "R7 acc01 read");
        // R5 high byte only, channel 1
        op(1, 0, 1, 3, 8'b01_10_011_0, "R3 ctl ch1");
        op(1, 0, 1, 1, 8'h9C, "R5 high load");
        rd_check(1, "R7 acc10 read");
        // R6 pair on channel 2
        op(1, 0, 1, 3, 8'b10_11_100_0, "R3 ctl ch2");
        op(1, 0, 1, 2, 8'h11, "R6 first byte no load");
        op(1, 0, 1, 2, 8'h22, "R6 second byte load");
        op(1, 0, 1, 2, 8'h33, "R6 restart low");
        op(1, 0, 1, 3, 8'b10_11_100_0, "R3 ptr reset");
        op(1, 0, 1, 2, 8'h44, "R6 low after reset");
        op(1, 0, 1, 2, 8'h55, "R6 high after reset");
        // R2 cs low
        op(0, 0, 1, 2, 8'h66, "R2 cs low write");
        op(0, 0, 1, 3, 8'b10_01_001_1, "R2 cs low ctl");
        // R8 capture and hold
        cur[2] = 16'hBEEF;
        op(1, 0, 1, 3, 8'b10_00_000_0, "R8 capture");
        cur[2] = 16'h0001;
        op(1, 0, 1, 3, 8'b10_00_000_0, "R8 second capture ignored");
        rd_check(2, "R8 held low");
        cur[2] = 16'h7777;
        rd_check(2, "R8 held high");
        rd_check(2, "R8 live after release");
        rd_check(2, "R7 live high");
        // R9 config cancels hold
        op(1, 0, 1, 3, 8'b10_00_000_0, "R9 capture");
        op(1, 0, 1, 3, 8'b10_10_101_0, "R9 reconfig");
        cur[2] = 16'h5A5A;
        rd_check(2, "R9 live after cancel");
        // R10
        rd_check(3, "R10 ctl read");
        op(1, 0, 1, 3, 8'b11_01_111_1, "R10 sel3 ignored");
        // R11 rd+wr on channel 0 (acc01)
        op(1, 1, 1, 0, 8'h7E, "R11 write wins");
        op(1, 0, 1, 3, 8'b00_11_011_0, "R11 ctl");
        op(1, 1, 1, 0, 8'h01, "R11 low via rd+wr");
        rd_check(0, "R11 rptr unmoved");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int k = $urandom_range(0, 9);
            logic [1:0] a = 2'($urandom_range(0, 3));
            logic [7:0] d = 8'($urandom);
            for (int c = 0; c < 3; c++) if ($urandom_range(0, 3) == 0) cur[c] = 16'($urandom);
            if (k < 3)      op(1, 0, 1, 3, d, "random R3");
            else if (k < 6) op(1, 0, 1, a, d, "random R6");
            else if (k < 9) op(1, 1, 0, a, d, "random R7");
            else            op($urandom_range(0, 1) == 1, 1, 1, a, d, "random R11");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule